// File: doc/BRIEF.md
# Indirect Register Access Window

This block sits between a 16-bit processor core and a coprocessor whose internal state is far larger than the core can address directly. The core sees only three registers, chosen by a 2-bit selector: an address pointer, a data port and a command register. Writing the pointer picks one internal word. Every read or write through the data port reaches that word and then moves the pointer on by one, so that blocks of words can be streamed with no further pointer writes.

The internal words are modelled as a generic file of 16-bit registers covering addresses 0x000 through a parameterised last address, which defaults to 0x410. A register wider than 16 bits occupies consecutive words, with the least significant word at the lowest address. A write to the command register latches an opcode, raises a one-cycle start strobe toward the engine, and sets a busy flag. The busy flag clears when the engine reports completion.

Selector encoding: 2'b00 is the pointer, 2'b01 is the data port, 2'b10 is the command register, and 2'b11 is unused (it reads as zero and ignores writes). Read data is registered and appears on `host_rdata` one clock after the read strobe. It then holds until the next read.

Top module: `cop_reg_window`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0, `host_rdata` is 0, `cmd_start` is 0, `cmd_busy` is 0 and `cmd_opcode` is 0.
- R2: A write with selector 2'b00 loads bits [10:0] of the write data into the pointer and ignores bits [15:11]. A read with selector 2'b00 returns the pointer in bits [10:0] with bits [15:11] zero.
- R3: A write with selector 2'b01 stores the write data in the word the pointer selects, and the pointer then advances by one.
- R4: A read with selector 2'b01 returns the selected word on `host_rdata` one clock later, and the pointer advances by one.
- R5: When read and write strobes are both asserted with selector 2'b01, the read returns the word's old contents and the write data is stored in that same word. The pointer advances exactly once.
- R6: The pointer is 11 bits wide and wraps from 0x7FF to 0x000 when it advances.
- R7: For any pointer value above the last implemented address (0x410), data-port reads return 0, data-port writes change no word, and the pointer still advances.
- R8: A write with selector 2'b10 latches bits [7:0] into `cmd_opcode` and drives `cmd_start` high for exactly the one following cycle.
- R9: A command write sets `cmd_busy`. `cmd_busy` clears the cycle after `eng_done`, unless a command write arrives in the same cycle, in which case it stays set. A read with selector 2'b10 returns busy in bit 15, the opcode in bits [7:0], and zeros in bits [14:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 2 | Register selector: 00 pointer, 01 data port, 10 command |
| host_rd | input | 1 | Read strobe for the selected register |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | 16 | Write data from the core |
| host_rdata | output | 16 | Registered read data, valid one clock after `host_rd` |
| eng_done | input | 1 | Completion pulse from the coprocessor engine |
| cmd_start | output | 1 | One-cycle start strobe to the engine |
| cmd_opcode | output | 8 | Latched opcode from the last command write |
| cmd_busy | output | 1 | High from a command write until completion |

## Verification
Every result of this block is due one clock edge after the strobe that causes it. Read data, a pointer step, a stored word, the start strobe, the opcode latch and a change in busy all follow their cause by a single clock. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. On each following falling edge it compares all outputs with that model, so every result is checked in exactly the cycle it is due. Directed checks read back the pointer, stored words and the command register through the selector, so that increments, wraps, ignored writes and compound accesses are confirmed through the ports.

// File: rtl/cop_win_pkg.sv
// Package: shared widths and selector encoding for the indirect register window.
// Assumes a 16-bit host data bus and an 11-bit internal address pointer.
package cop_win_pkg;
    localparam int DW = 16;
    localparam int AW = 11;
    localparam int OPW = 8;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'b00,
        SEL_DATA = 2'b01,
        SEL_CMD  = 2'b10,
        SEL_NONE = 2'b11
    } win_sel_e;
endpackage

// File: rtl/cop_ptr.sv
// Module: address pointer. It loads on a pointer write and advances by one on a
// data-port access, wrapping naturally at its width. It assumes that load and
// step never arrive in the same cycle, because they come from different selectors.
module cop_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    // Pointer register: load, single step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ld)
            ptr <= ld_val;
        else if (step)
            ptr <= ptr + 1'b1;
    end

    // R2: the loaded value appears on the next cycle.
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ptr == $past(ld_val));
    // R6: stepping from the top address wraps to zero.
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && ptr == {AW{1'b1}}) |=> ptr == '0);
    // R5: when no access occurs, the pointer holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=> $stable(ptr));
endmodule

// File: rtl/cop_regfile.sv
// Module: generic internal word file standing in for the coprocessor's registers.
// Words 0..LAST are implemented. Reads of addresses above LAST give zero, and
// writes there are dropped. The read port is combinational, so a read in the
// same cycle as a write returns the old contents.
module cop_regfile #(
    parameter int DW   = 16,
    parameter int AW   = 11,
    parameter int LAST = 'h410
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rword
);
    localparam int DEPTH = LAST + 1;

    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    assign hit = (int'(addr) <= LAST);

    // Word storage: cleared on reset, written only inside the implemented range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we && hit) begin
            mem[int'(addr)] <= wdata;
        end
    end

    // Read selection: addresses above the implemented range give zero.
    always_comb begin
        rword = '0;
        if (hit)
            rword = mem[int'(addr)];
    end

    // R3: a write inside the range is visible at that address on the next cycle.
    a_r3_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit) |=> (rword == $past(wdata)) || (addr != $past(addr)));
endmodule

// File: rtl/cop_cmd.sv
// Module: command register. A write latches the opcode, raises a one-cycle start
// strobe and sets busy. Busy clears on engine completion, and a new write
// arriving in the same cycle as completion takes priority.
module cop_cmd #(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [OPW-1:0] op_in,
    input  logic           done,
    output logic           start,
    output logic [OPW-1:0] opcode,
    output logic           busy
);
    // Opcode latch and start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
            start  <= 1'b0;
        end else begin
            start <= wr;
            if (wr)
                opcode <= op_in;
        end
    end

    // Busy flag: set by a write, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (wr)
            busy <= 1'b1;
        else if (done)
            busy <= 1'b0;
    end

    // R8: a start strobe only ever follows a command write.
    a_r8_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(wr));
    // R8: a lone write gives a strobe lasting exactly one cycle.
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !$past(start) && !wr) |=> !start);
    // R9: busy is set after a write, even when completion arrives in the same cycle.
    a_r9_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> busy);
    // R9: completion without a write clears busy.
    a_r9_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr) |=> !busy);
endmodule

// File: rtl/cop_reg_window.sv
// Module: top of the indirect register window. It decodes the selector into a
// pointer load, a data-port access or a command write, and registers the read
// data. It assumes the host raises at most one access per cycle, where a
// compound data-port access (read and write together) counts as one access.
module cop_reg_window #(
    parameter int LAST = 'h410
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_sel,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        eng_done,
    output logic        cmd_start,
    output logic [7:0]  cmd_opcode,
    output logic        cmd_busy
);
    import cop_win_pkg::*;

    localparam int PAD_P = DW - AW;
    localparam int PAD_C = DW - 1 - OPW;

    win_sel_e        sel;
    logic [AW-1:0]   ptr;
    logic [DW-1:0]   rword;
    logic            ptr_ld;
    logic            data_acc;
    logic            data_we;
    logic            cmd_wr;

    assign sel      = win_sel_e'(host_sel);
    assign ptr_ld   = host_wr && (sel == SEL_PTR);
    assign data_acc = (host_rd || host_wr) && (sel == SEL_DATA);
    assign data_we  = host_wr && (sel == SEL_DATA);
    assign cmd_wr   = host_wr && (sel == SEL_CMD);

    cop_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ptr_ld),
        .ld_val (host_wdata[AW-1:0]),
        .step   (data_acc),
        .ptr    (ptr)
    );

    cop_regfile #(.DW(DW), .AW(AW), .LAST(LAST)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (ptr),
        .we    (data_we),
        .wdata (host_wdata),
        .rword (rword)
    );

    cop_cmd #(.OPW(OPW)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmd_wr),
        .op_in  (host_wdata[OPW-1:0]),
        .done   (eng_done),
        .start  (cmd_start),
        .opcode (cmd_opcode),
        .busy   (cmd_busy)
    );

    // Read-back register: captures the selected source on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            unique case (sel)
                SEL_PTR:  host_rdata <= {{PAD_P{1'b0}}, ptr};
                SEL_DATA: host_rdata <= rword;
                SEL_CMD:  host_rdata <= {cmd_busy, {PAD_C{1'b0}}, cmd_opcode};
                default:  host_rdata <= '0;
            endcase
        end
    end

    // R7: a data-port read above the implemented range returns zero.
    a_r7_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel == SEL_DATA && int'(ptr) > LAST) |=> host_rdata == '0);
    // R9: the reserved bits of the command read-back are zero.
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel == SEL_CMD) |=> host_rdata[DW-2:OPW] == '0);
    // R2: the upper bits of the pointer read-back are zero.
    a_r2_ptr_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel == SEL_PTR) |=> host_rdata[DW-1:AW] == '0);
    // R4: read data holds while no read is issued.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/tb_cop_reg_window.sv
// Bench: a behavioural model updated on each rising edge and compared with every
// output on each falling edge, plus directed read-back checks.
module tb_cop_reg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'b11;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        eng_done = 1'b0;
    logic        cmd_start;
    logic [7:0]  cmd_opcode;
    logic        cmd_busy;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit started = 1'b0;

    // Model state.
    logic [15:0] m_mem [int];
    int          m_ptr = 0;
    logic [15:0] m_rdata = '0;
    logic        m_start = 1'b0;
    logic [7:0]  m_op = '0;
    logic        m_busy = 1'b0;

    always #5 clk = ~clk;

    cop_reg_window dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_done(eng_done), .cmd_start(cmd_start), .cmd_opcode(cmd_opcode),
        .cmd_busy(cmd_busy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_mem.delete();
            m_ptr = 0; m_rdata = '0; m_start = 1'b0; m_op = '0; m_busy = 1'b0;
        end else begin
            if (host_rd) begin
                case (host_sel)
                    2'b00: m_rdata = 16'(m_ptr);
                    2'b01: m_rdata = (m_ptr <= 'h410 && m_mem.exists(m_ptr)) ? m_mem[m_ptr] : 16'h0;
                    2'b10: m_rdata = {m_busy, 7'b0, m_op};
                    default: m_rdata = '0;
                endcase
            end
            m_start = (host_wr && host_sel == 2'b10);
            if (host_wr && host_sel == 2'b10) begin
                m_op = host_wdata[7:0];
                m_busy = 1'b1;
            end else if (eng_done) begin
                m_busy = 1'b0;
            end
            if (host_wr && host_sel == 2'b01 && m_ptr <= 'h410)
                m_mem[m_ptr] = host_wdata;
            if (host_wr && host_sel == 2'b00)
                m_ptr = int'(host_wdata[10:0]);
            else if ((host_rd || host_wr) && host_sel == 2'b01)
                m_ptr = (m_ptr + 1) % 2048;
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk({cur_req, " rdata"}, host_rdata, m_rdata);
            chk({cur_req, " start"}, {15'b0, cmd_start}, {15'b0, m_start});
            chk({cur_req, " opcode"}, {8'b0, cmd_opcode}, {8'b0, m_op});
            chk({cur_req, " busy"}, {15'b0, cmd_busy}, {15'b0, m_busy});
        end
    end

    // One bus cycle: drive on the falling edge, release after the next one.
    task automatic cyc(input logic [1:0] s, input logic rd, input logic wr, input logic [15:0] d);
        host_sel = s; host_rd = rd; host_wr = wr; host_wdata = d;
        @(negedge clk);
        host_sel = 2'b11; host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input string req, input logic [15:0] exp);
        cyc(s, 1'b1, 1'b0, '0);
        chk(req, host_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 rdata", host_rdata, 16'h0);
        chk("R1 busy/start", {14'b0, cmd_busy, cmd_start}, 16'h0);
        chk("R1 opcode", {8'b0, cmd_opcode}, 16'h0);
        rst_n = 1'b1;
        rd_chk(2'b00, "R1 ptr", 16'h0000);

        cur_req = "R2";
        cyc(2'b00, 1'b0, 1'b1, 16'hF805);
        rd_chk(2'b00, "R2 ptr load", 16'h0005);

        cur_req = "R3";
        cyc(2'b01, 1'b0, 1'b1, 16'h1111);
        cyc(2'b01, 1'b0, 1'b1, 16'h2222);
        cyc(2'b01, 1'b0, 1'b1, 16'h3333);
        rd_chk(2'b00, "R3 ptr step", 16'h0008);

        cur_req = "R4";
        cyc(2'b00, 1'b0, 1'b1, 16'h0005);
        rd_chk(2'b01, "R4 word5", 16'h1111);
        rd_chk(2'b01, "R4 word6", 16'h2222);
        rd_chk(2'b01, "R4 word7", 16'h3333);
        rd_chk(2'b00, "R4 ptr", 16'h0008);

        cur_req = "R5";
        cyc(2'b00, 1'b0, 1'b1, 16'h0006);
        cyc(2'b01, 1'b1, 1'b1, 16'hABCD);
        chk("R5 old data", host_rdata, 16'h2222);
        rd_chk(2'b00, "R5 single step", 16'h0007);
        cyc(2'b00, 1'b0, 1'b1, 16'h0006);
        rd_chk(2'b01, "R5 new data", 16'hABCD);

        cur_req = "R6";
        cyc(2'b00, 1'b0, 1'b1, 16'h07FF);
        cyc(2'b01, 1'b0, 1'b1, 16'h7777);
        rd_chk(2'b00, "R6 wrap", 16'h0000);

        cur_req = "R7";
        cyc(2'b00, 1'b0, 1'b1, 16'h07FF);
        rd_chk(2'b01, "R7 high word", 16'h0000);
        cyc(2'b00, 1'b0, 1'b1, 16'h0410);
        cyc(2'b01, 1'b0, 1'b1, 16'h5A5A);
        cyc(2'b01, 1'b0, 1'b1, 16'h1234);
        cyc(2'b00, 1'b0, 1'b1, 16'h0410);
        rd_chk(2'b01, "R7 last word", 16'h5A5A);
        rd_chk(2'b01, "R7 beyond last", 16'h0000);
        rd_chk(2'b00, "R7 ptr step", 16'h0412);

        cur_req = "R8";
        cyc(2'b10, 1'b0, 1'b1, 16'hFF3C);
        chk("R8 start pulse", {15'b0, cmd_start}, 16'h1);
        chk("R8 opcode", {8'b0, cmd_opcode}, 16'h003C);
        @(negedge clk);
        chk("R8 start drop", {15'b0, cmd_start}, 16'h0);

        cur_req = "R9";
        rd_chk(2'b10, "R9 busy readback", 16'h803C);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R9 busy clear", {15'b0, cmd_busy}, 16'h0);
        rd_chk(2'b10, "R9 idle readback", 16'h003C);
        eng_done = 1'b1;
        cyc(2'b10, 1'b0, 1'b1, 16'h0041);
        eng_done = 1'b0;
        chk("R9 write beats done", {15'b0, cmd_busy}, 16'h1);
        rd_chk(2'b11, "R9 unused selector", 16'h0000);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule